// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block gathers eight level-sensitive interrupt request lines, arbitrates them by fixed priority and raises a single interrupt line towards a processor. When the processor answers with a one-cycle acknowledge, the block places an 8-bit vector on its output during that same cycle. The vector is a programmable base plus the index of the winning input. Unless automatic end-of-interrupt is enabled, the winning input is also marked as in service.

Software uses two addresses. A command address starts the configuration sequence and takes end-of-interrupt and read-select commands. A data address takes the configuration words, then the mask, and reads back the mask. The configuration sequence stores the vector base and a cascade word. The cascade word is a bitmap of inputs that have a downstream controller attached, or the upstream input number when the block is the downstream one. An optional mode word carries the automatic end-of-interrupt enable. An acknowledge that finds no eligible request returns the vector for input 7 and leaves the in-service state untouched.

Top module: `pvic_top`

## Requirements
- R1: After reset the mask reads 0xFF, the in-service register is 0, cpu_int is low, casc_cfg is 0, and command-address reads return the request register.
- R2: A command write with bit 4 set starts configuration. It clears the mask, the in-service register and the automatic end-of-interrupt enable, and selects the request register for reads. The next data writes load the vector base and then the cascade word. A mode word follows only when bit 0 of the start command was 1. After that, data writes go to the mask again.
- R3: While cpu_ack is high and an eligible request exists, vec_out equals base plus the index of the highest-priority eligible input (8-bit sum). On that edge the matching in-service bit is set.
- R4: Input 0 has the highest priority. An unmasked request is eligible only if its index is lower than that of every set in-service bit. cpu_int is high exactly when an eligible request exists.
- R5: Outside configuration, a data write loads the mask, where a 1 blocks that input. A data-address read returns the mask.
- R6: A command write whose bits [7:3] are 01100 clears only the in-service bit numbered by bits [2:0].
- R7: A command write with bit 4 clear and bits 3 and 1 set selects what command reads return: the in-service register when bit 0 is 1 (0x0B), the request register when bit 0 is 0 (0x0A).
- R8: When bit 1 of the mode word is set, an acknowledge returns the vector but sets no in-service bit.
- R9: An acknowledge while no request is eligible returns base+7 and changes no in-service bit, even when input 7 is masked.
- R10: casc_cfg shows the cascade word stored by the last configuration sequence.
- R11: A specific end-of-interrupt written in the same cycle as an acknowledge applies both: the named bit is cleared and the winner's bit is set.
- R12: The request register samples irq_in every clock, so a command-address read reflects the inputs one cycle late.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Address select: 0 command, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| irq_in | input | 8 | Level-sensitive request lines |
| cpu_int | output | 1 | Interrupt request towards the processor |
| cpu_ack | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector, valid while cpu_ack is high |
| vec_valid | output | 1 | High while vec_out carries a vector |
| casc_cfg | output | 8 | Stored cascade word |

## Verification
The in-service register has two writers: the acknowledge, which sets the winner's bit, and the specific end-of-interrupt command, which clears a named bit. Both can fall on the same clock edge. The bench first leaves input 1 in service. It then raises input 0 and, in a single cycle, asserts cpu_ack and writes the end-of-interrupt for level 1. The check requires vector base+0 and an in-service register of exactly 0x01, so that neither update was lost.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int NUM_IRQ = 8;
  localparam int IDX_W   = $clog2(NUM_IRQ);

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} cfg_st_t;

  // lowest set index of a request vector (0 when empty)
  function automatic logic [IDX_W-1:0] pick_first(input logic [NUM_IRQ-1:0] req);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_IRQ-1; i >= 0; i--)
      if (req[i]) r = IDX_W'(i);
    return r;
  endfunction

  // bits 0..idx set
  function automatic logic [NUM_IRQ-1:0] up_to(input logic [IDX_W-1:0] idx);
    logic [NUM_IRQ-1:0] m;
    for (int i = 0; i < NUM_IRQ; i++)
      m[i] = (IDX_W'(i) <= idx);
    return m;
  endfunction

  function automatic logic [7:0] vec_calc(input logic [7:0] base, input logic [IDX_W-1:0] idx);
    return base + 8'(idx);
  endfunction

  function automatic logic [NUM_IRQ-1:0] one_hot(input logic [IDX_W-1:0] idx);
    return NUM_IRQ'(1) << idx;
  endfunction
endpackage

// File: rtl/pvic_regif.sv
module pvic_regif
  import pvic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [7:0]         wdata,
  output logic [NUM_IRQ-1:0] mask_q,
  output logic [7:0]         base_q,
  output logic [7:0]         casc_q,
  output logic               aeoi_q,
  output logic               rd_isr_q,
  output logic               in_run,
  output logic               cfg_start,
  output logic [NUM_IRQ-1:0] eoi_clr
);
  cfg_st_t st_q;
  logic    want_mode_q;

  logic cmd_wr, dat_wr, sel_cmd, eoi_cmd;
  assign cmd_wr    = wr_en & ~wr_sel;
  assign dat_wr    = wr_en &  wr_sel;
  assign cfg_start = cmd_wr &  wdata[4];
  assign sel_cmd   = cmd_wr & ~wdata[4] &  wdata[3];
  assign eoi_cmd   = cmd_wr & ~wdata[4] & ~wdata[3] & (wdata[7:5] == 3'b011);
  assign eoi_clr   = eoi_cmd ? one_hot(wdata[IDX_W-1:0]) : '0;
  assign in_run    = (st_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      mask_q      <= '1;
      base_q      <= '0;
      casc_q      <= '0;
      aeoi_q      <= 1'b0;
      rd_isr_q    <= 1'b0;
      want_mode_q <= 1'b0;
    end else if (cfg_start) begin
      st_q        <= ST_BASE;
      mask_q      <= '0;
      aeoi_q      <= 1'b0;
      rd_isr_q    <= 1'b0;
      want_mode_q <= wdata[0];
    end else begin
      if (sel_cmd && wdata[1]) rd_isr_q <= wdata[0];
      if (dat_wr) begin
        unique case (st_q)
          ST_BASE: begin base_q <= wdata; st_q <= ST_CASC; end
          ST_CASC: begin casc_q <= wdata; st_q <= want_mode_q ? ST_MODE : ST_RUN; end
          ST_MODE: begin aeoi_q <= wdata[1]; st_q <= ST_RUN; end
          default: mask_q <= wdata[NUM_IRQ-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
  import pvic_pkg::*;
(
  input  logic [NUM_IRQ-1:0] req,
  input  logic [NUM_IRQ-1:0] isr,
  output logic               any_elig,
  output logic [IDX_W-1:0]   win_idx
);
  logic blocked;
  assign win_idx  = pick_first(req);
  assign blocked  = |(isr & up_to(win_idx));
  assign any_elig = (|req) & ~blocked;
endmodule

// File: rtl/pvic_state.sv
module pvic_state
  import pvic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               clr_all,
  input  logic [NUM_IRQ-1:0] eoi_clr,
  input  logic [NUM_IRQ-1:0] ack_set,
  output logic [NUM_IRQ-1:0] irr_q,
  output logic [NUM_IRQ-1:0] isr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= irq_in;
      if (clr_all) isr_q <= '0;
      else         isr_q <= (isr_q & ~eoi_clr) | ack_set;
    end
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] irq_in,
  output logic       cpu_int,
  input  logic       cpu_ack,
  output logic [7:0] vec_out,
  output logic       vec_valid,
  output logic [7:0] casc_cfg
);
  logic [NUM_IRQ-1:0] mask_q, irr_q, isr_q, eoi_clr, ack_set, req;
  logic [7:0]         base_q;
  logic               aeoi_q, rd_isr_q, in_run, cfg_start, any_elig;
  logic [IDX_W-1:0]   win_idx;

  pvic_regif u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_sel(bus_sel), .wdata(bus_wdata),
    .mask_q(mask_q), .base_q(base_q), .casc_q(casc_cfg), .aeoi_q(aeoi_q),
    .rd_isr_q(rd_isr_q), .in_run(in_run), .cfg_start(cfg_start), .eoi_clr(eoi_clr)
  );

  assign req = irr_q & ~mask_q;

  pvic_arb u_arb (.req(req), .isr(isr_q), .any_elig(any_elig), .win_idx(win_idx));

  assign ack_set = (cpu_ack && any_elig && !aeoi_q) ? one_hot(win_idx) : '0;

  pvic_state u_state (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_all(cfg_start),
    .eoi_clr(eoi_clr), .ack_set(ack_set), .irr_q(irr_q), .isr_q(isr_q)
  );

  assign cpu_int   = any_elig;
  assign vec_valid = cpu_ack;
  assign vec_out   = cpu_ack ? vec_calc(base_q, any_elig ? win_idx : IDX_W'(NUM_IRQ-1)) : 8'h00;
  assign bus_rdata = bus_sel ? mask_q : (rd_isr_q ? isr_q : irr_q);
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wdata,
  input logic       cpu_ack,
  input logic       cpu_int,
  input logic [7:0] vec_out,
  input logic [7:0] base,
  input logic [7:0] isr,
  input logic [7:0] irr,
  input logic [7:0] mask,
  input logic       aeoi,
  input logic       in_run
);
  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wdata[4]) |=> (isr == 8'h00 && mask == 8'h00)); // R2
  AST_ACK_SETS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_int && !aeoi && !wr_en) |=> ($countones(isr) == $countones($past(isr)) + 1)); // R3
  AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((irr & ~mask) != 8'h00)); // R4
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && in_run) |=> (mask == $past(wdata))); // R5
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wdata[7:3] == 5'b01100 && !cpu_ack) |=> !isr[$past(wdata[2:0])]); // R6
  AST_AUTO_EOI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && aeoi && !wr_en) |=> (isr == $past(isr))); // R8
  AST_SPUR_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_int) |-> (vec_out == 8'(base + 8'd7))); // R9
  AST_SPUR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_int && !wr_en) |=> (isr == $past(isr))); // R9
  AST_COLLIDE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_int && !aeoi && wr_en && !wr_sel && wdata[7:3] == 5'b01100) |=> (isr != 8'h00)); // R11
endmodule

bind pvic_top pvic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_sel(bus_sel), .wdata(bus_wdata),
  .cpu_ack(cpu_ack), .cpu_int(cpu_int), .vec_out(vec_out), .base(base_q),
  .isr(isr_q), .irr(irr_q), .mask(mask_q), .aeoi(aeoi_q), .in_run(in_run)
);

// File: tb/pvic_top_tb.sv
module pvic_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_sel = 1'b0, cpu_ack = 1'b0;
  logic [7:0] bus_wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] bus_rdata, vec_out, casc_cfg;
  logic       cpu_int, vec_valid;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pvic_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_in(irq_in), .cpu_int(cpu_int), .cpu_ack(cpu_ack),
    .vec_out(vec_out), .vec_valid(vec_valid), .casc_cfg(casc_cfg)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    bus_sel = sel; #1 v = bus_rdata;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); cpu_ack = 1'b1; #1 v = vec_out;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] start, input logic [7:0] base, input logic [7:0] casc,
                     input logic [7:0] mode);
    wr(1'b0, start); wr(1'b1, base); wr(1'b1, casc);
    if (start[0]) wr(1'b1, mode);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1;
    chk("R1 cpu_int", {7'd0, cpu_int}, 8'h00);
    rd(1'b1, v); chk("R1 mask", v, 8'hFF);
    rd(1'b0, v); chk("R1 irr read", v, 8'h00);
    chk("R1 casc", casc_cfg, 8'h00);
  endtask

  task automatic t_config();
    logic [7:0] v;
    cfg(8'h11, 8'h20, 8'h04, 8'h01);
    rd(1'b1, v); chk("R2 mask cleared", v, 8'h00);
    chk("R10 casc", casc_cfg, 8'h04);
    wr(1'b1, 8'hF0); rd(1'b1, v); chk("R2 R5 back to mask", v, 8'hF0);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_prio_eoi();
    logic [7:0] v;
    set_irq(8'h28); #1;
    chk("R4 int raised", {7'd0, cpu_int}, 8'h01);
    rd(1'b0, v); chk("R12 irr read", v, 8'h28);
    ack(v); chk("R3 vec in3", v, 8'h23);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R7 isr read", v, 8'h08);
    #1 chk("R4 lower blocked", {7'd0, cpu_int}, 8'h00);
    set_irq(8'h2A); #1;
    chk("R4 higher passes", {7'd0, cpu_int}, 8'h01);
    ack(v); chk("R3 vec in1", v, 8'h21);
    rd(1'b0, v); chk("R3 isr nested", v, 8'h0A);
    wr(1'b0, 8'h61); rd(1'b0, v); chk("R6 clears only 1", v, 8'h08);
    set_irq(8'h28);
    wr(1'b0, 8'h63); rd(1'b0, v); chk("R6 clear 3", v, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R7 back to irr", v, 8'h28);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(1'b1, 8'h08); #1;
    ack(v); chk("R5 masked skipped", v, 8'h25);
    wr(1'b0, 8'h65);
    wr(1'b1, 8'h28); #1;
    chk("R5 all masked", {7'd0, cpu_int}, 8'h00);
    rd(1'b1, v); chk("R5 mask read", v, 8'h28);
  endtask

  task automatic t_spurious();
    logic [7:0] v;
    wr(1'b1, 8'h80); set_irq(8'h00);
    ack(v); chk("R9 spurious vec", v, 8'h27);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R9 isr untouched", v, 8'h00);
  endtask

  task automatic t_auto_eoi();
    logic [7:0] v;
    cfg(8'h11, 8'h28, 8'h02, 8'h03);
    chk("R10 slave casc", casc_cfg, 8'h02);
    set_irq(8'h04);
    ack(v); chk("R8 vec", v, 8'h2A);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R8 no isr", v, 8'h00);
    #1 chk("R8 int stays", {7'd0, cpu_int}, 8'h01);
  endtask

  task automatic t_no_mode_word();
    logic [7:0] v;
    set_irq(8'h00);
    cfg(8'h10, 8'h40, 8'h04, 8'h00);
    wr(1'b1, 8'h55); rd(1'b1, v); chk("R2 no mode word", v, 8'h55);
    set_irq(8'h02);
    ack(v); chk("R3 new base", v, 8'h41);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R2 auto eoi cleared", v, 8'h02);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wr(1'b1, 8'h00); set_irq(8'h03);
    @(negedge clk);
    cpu_ack = 1'b1; bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = 8'h61;
    #1 v = vec_out; chk("R11 vec in0", v, 8'h40);
    @(negedge clk); cpu_ack = 1'b0; bus_wr = 1'b0;
    rd(1'b0, v); chk("R11 both applied", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_prio_eoi();
    t_mask();
    t_spurious();
    t_auto_eoi();
    t_no_mode_word();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule